// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog that runs from its own slow tick. The tick comes in as a one-cycle enable on the block clock. Software controls it through a small register port. A 16-bit key register takes magic words. One word starts the watchdog. A second word restarts the countdown window (a refresh). A third word opens the divider and reload registers for writing. Any other key write closes them again. Once started, the watchdog keeps running until the block is reset.

The block divides the slow tick by a power of two picked by a 3-bit code. Each divided tick steps a 12-bit down-counter, which starts from the reload value. Stepping the counter while it is at zero raises a one-cycle reset request. The counter then reloads and keeps counting.

Writes to the divider and reload registers land in holding copies first. The counting logic takes a new value on the next slow tick. Until then, a status bit for that register reads 1. This mimics the transfer into a slower clock domain.

Top module: `key_watchdog`

## Requirements
- R1: After reset, the divider register reads 0, the reload register reads 0xFFF, the status register reads 0, and `rst_req_o` is 0.
- R2: Register addresses are: 0 key (write-only, reads 0), 1 divider code in bits [2:0], 2 reload value in bits [11:0], 3 status. Writing key 0x5555 opens registers 1 and 2, and accepted writes read back at once.
- R3: A write to register 1 or 2 while it is closed changes nothing. Any key write other than 0x5555 closes both registers.
- R4: An accepted write to register 1 sets status bit 0, and an accepted write to register 2 sets status bit 1. Each bit clears on the next slow tick, when the new value reaches the counting logic.
- R5: Key 0xCCCC starts the watchdog. Before it is started, no reset request is raised, whatever ticks arrive.
- R6: After a start or refresh, the reset request rises one cycle after the clock edge that takes slow tick number (reload+1)·(4·2^code).
- R7: Divider codes 7 and above behave as code 6 (divide by 256).
- R8: Key 0xAAAA, written while running, restarts the full window from the active reload value.
- R9: The reset request is exactly one cycle wide. The counter then reloads, and the next request comes after another full window of ticks.
- R10: Once started, no register write stops the watchdog. Other key words do not disturb the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Slow tick enable, one cycle per tick |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for write and read |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The assertions assume that `tick_i` comes as single-cycle enables and is never high in the same cycle as a key write. A refresh or start that meets a tick leaves the divided-tick phase undefined. The stimulus keeps the tick low during every register write. It waits for each pending status bit to clear before a refresh. It then measures each window with a steady tick stream, so the tick count to the request can be compared with the computed window length.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int unsigned KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;

  typedef enum logic [1:0] {
    ADDR_KEY = 2'd0,
    ADDR_DIV = 2'd1,
    ADDR_RLD = 2'd2,
    ADDR_STS = 2'd3
  } wdg_addr_e;
endpackage

// File: rtl/wdg_key_ctrl.sv
module wdg_key_ctrl
  import wdg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_wr_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             unlocked_o,
  output logic             running_o,
  output logic             start_o,
  output logic             refresh_o
);
  logic is_unlock, is_start, is_refresh;

  assign is_unlock  = (key_i == KEY_UNLOCK);
  assign is_start   = (key_i == KEY_START);
  assign is_refresh = (key_i == KEY_REFRESH);

  assign start_o   = key_wr_i && is_start && !running_o;
  assign refresh_o = key_wr_i && is_refresh && running_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlocked_o <= 1'b0;
      running_o  <= 1'b0;
    end else if (key_wr_i) begin
      unlocked_o <= is_unlock;
      // sticky: only reset leaves the running state
      if (is_start) running_o <= 1'b1;
    end
  end
endmodule

// File: rtl/wdg_cfg_reg.sv
module wdg_cfg_reg #(
  parameter int unsigned         W       = 12,
  parameter logic [W-1:0]        RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         tick_i,
  output logic [W-1:0] shadow_o,
  output logic [W-1:0] active_o,
  output logic         pending_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_o  <= RST_VAL;
      active_o  <= RST_VAL;
      pending_o <= 1'b0;
    end else if (wr_i) begin
      // new write wins over a same-cycle transfer
      shadow_o  <= wdata_i;
      pending_o <= 1'b1;
    end else if (tick_i && pending_o) begin
      active_o  <= shadow_o;
      pending_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int unsigned PR_W   = 3,
  parameter int unsigned PR_MAX = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            clr_i,
  input  logic            tick_i,
  input  logic [PR_W-1:0] code_i,
  output logic            dec_o
);
  localparam int unsigned PS_W = PR_MAX + 2;

  logic [PR_W-1:0] code_c;
  logic [PS_W-1:0] div_m1;
  logic [PS_W-1:0] cnt_q;
  logic            wrap;

  assign code_c = (code_i > PR_W'(PR_MAX)) ? PR_W'(PR_MAX) : code_i;
  // 4 << code wraps to 0 at the top code, so minus one gives all ones
  assign div_m1 = PS_W'(PS_W'(4) << code_c) - PS_W'(1);
  assign wrap   = (cnt_q == div_m1);
  assign dec_o  = en_i && !clr_i && tick_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i || !en_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= wrap ? '0 : cnt_q + PS_W'(1);
    end
  end
endmodule

// File: rtl/wdg_down_counter.sv
module wdg_down_counter #(
  parameter int unsigned RL_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            dec_i,
  input  logic [RL_W-1:0] reload_i,
  output logic            expire_o
);
  logic [RL_W-1:0] cnt_q;
  logic            at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '1;
      expire_o <= 1'b0;
    end else begin
      expire_o <= dec_i && at_zero && !load_i;
      if (load_i)      cnt_q <= reload_i;
      else if (dec_i)  cnt_q <= at_zero ? reload_i : cnt_q - RL_W'(1);
    end
  end
endmodule

// File: rtl/key_watchdog.sv
module key_watchdog
  import wdg_pkg::*;
#(
  parameter int unsigned PR_W   = 3,
  parameter int unsigned PR_MAX = 6,
  parameter int unsigned RL_W   = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [KEY_W-1:0] wdata_i,
  output logic [KEY_W-1:0] rdata_o,
  output logic             rst_req_o
);
  localparam logic [RL_W-1:0] RL_RST = '1;
  localparam int unsigned     STS_W  = 2;

  logic            unlocked, running, start, refresh;
  logic            key_wr, pr_wr, rl_wr;
  logic [PR_W-1:0] pr_shadow, pr_active;
  logic [RL_W-1:0] rl_shadow, rl_active;
  logic            pr_pend, rl_pend;
  logic            dec;
  logic [STS_W-1:0] status;

  assign key_wr = wr_en_i && (addr_i == ADDR_KEY);
  assign pr_wr  = wr_en_i && (addr_i == ADDR_DIV) && unlocked;
  assign rl_wr  = wr_en_i && (addr_i == ADDR_RLD) && unlocked;

  wdg_key_ctrl i_key_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_wr_i   (key_wr),
    .key_i      (wdata_i),
    .unlocked_o (unlocked),
    .running_o  (running),
    .start_o    (start),
    .refresh_o  (refresh)
  );

  wdg_cfg_reg #(.W(PR_W), .RST_VAL('0)) i_pr_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (pr_wr),
    .wdata_i   (wdata_i[PR_W-1:0]),
    .tick_i    (tick_i),
    .shadow_o  (pr_shadow),
    .active_o  (pr_active),
    .pending_o (pr_pend)
  );

  wdg_cfg_reg #(.W(RL_W), .RST_VAL(RL_RST)) i_rl_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (rl_wr),
    .wdata_i   (wdata_i[RL_W-1:0]),
    .tick_i    (tick_i),
    .shadow_o  (rl_shadow),
    .active_o  (rl_active),
    .pending_o (rl_pend)
  );

  wdg_prescaler #(.PR_W(PR_W), .PR_MAX(PR_MAX)) i_prescaler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (running),
    .clr_i  (start || refresh),
    .tick_i (tick_i),
    .code_i (pr_active),
    .dec_o  (dec)
  );

  wdg_down_counter #(.RL_W(RL_W)) i_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start || refresh),
    .dec_i    (dec),
    .reload_i (rl_active),
    .expire_o (rst_req_o)
  );

  assign status = {rl_pend, pr_pend};

  always_comb begin
    unique case (addr_i)
      ADDR_DIV: rdata_o = KEY_W'(pr_shadow);
      ADDR_RLD: rdata_o = KEY_W'(rl_shadow);
      ADDR_STS: rdata_o = KEY_W'(status);
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tick_i,
  input logic        wr_en_i,
  input logic [1:0]  addr_i,
  input logic [15:0] wdata_i,
  input logic        rst_req_o,
  input logic        running,
  input logic        unlocked,
  input logic        pr_pend,
  input logic [2:0]  pr_shadow
);
  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  a_r10_no_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running |=> running);

  a_r5_req_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> running);

  a_r2_unlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd0 && wdata_i == 16'h5555) |=> unlocked);

  a_r3_relock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd0 && wdata_i != 16'h5555) |=> !unlocked);

  a_r3_locked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd1 && !unlocked) |=> $stable(pr_shadow));

  a_r4_pend_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && pr_pend && !(wr_en_i && addr_i == 2'd1 && unlocked)) |=> !pr_pend);
endmodule

bind key_watchdog wdg_checker i_wdg_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rst_req_o (rst_req_o),
  .running   (running),
  .unlocked  (unlocked),
  .pr_pend   (pr_pend),
  .pr_shadow (pr_shadow)
);

// File: tb/test_key_watchdog.sv
`timescale 1ns/1ps
module test_key_watchdog;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        rst_req_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  key_watchdog i_key_watchdog (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rst_req_o(rst_req_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    tick_i = 1'b0; wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk_i);
    wr_en_i = 1'b0; addr_i = a;
    #1 v = int'(rdata_o);
  endtask

  task automatic one_tick();
    @(negedge clk_i);
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  // steady ticks, returns number of ticks until request (0 if none within max)
  task automatic measure(input int max, output int n);
    n = 0;
    @(negedge clk_i);
    tick_i = 1'b1;
    for (int k = 1; k <= max; k++) begin
      @(negedge clk_i);
      if (rst_req_o) begin n = k; break; end
    end
    tick_i = 1'b0;
  endtask

  task automatic configure(input int pr, input int rl);
    int v;
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'(pr));
    wr(2'd2, 16'(rl));
    one_tick();
    rd(2'd3, v);
    check(v == 0, "R4 status clear after tick", v, 0);
  endtask

  function automatic int window(input int pr, input int rl);
    int c = (pr > 6) ? 6 : pr;
    return (rl + 1) * (4 << c);
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, n, exp;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd(2'd1, v); check(v == 0, "R1 divider reset", v, 0);
    rd(2'd2, v); check(v == 12'hFFF, "R1 reload reset", v, 12'hFFF);
    rd(2'd3, v); check(v == 0, "R1 status reset", v, 0);
    check(rst_req_o == 1'b0, "R1 request low", int'(rst_req_o), 0);

    // R3 locked writes ignored
    wr(2'd1, 16'd5);
    wr(2'd2, 16'd7);
    rd(2'd1, v); check(v == 0, "R3 locked divider", v, 0);
    rd(2'd2, v); check(v == 12'hFFF, "R3 locked reload", v, 12'hFFF);
    rd(2'd3, v); check(v == 0, "R3 locked no pending", v, 0);

    // R2 unlock and readback, R4 pending bits
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'd3);
    rd(2'd3, v); check(v == 1, "R4 divider pending", v, 1);
    wr(2'd2, 16'd9);
    rd(2'd3, v); check(v == 3, "R4 both pending", v, 3);
    rd(2'd1, v); check(v == 3, "R2 divider readback", v, 3);
    rd(2'd2, v); check(v == 9, "R2 reload readback", v, 9);
    rd(2'd0, v); check(v == 0, "R2 key reads zero", v, 0);
    one_tick();
    rd(2'd3, v); check(v == 0, "R4 cleared by tick", v, 0);

    // R3 relock with other key
    wr(2'd0, 16'h1234);
    wr(2'd1, 16'd6);
    rd(2'd1, v); check(v == 3, "R3 relock divider", v, 3);
    wr(2'd2, 16'd1);
    rd(2'd2, v); check(v == 9, "R3 relock reload", v, 9);

    // R5 not running: no request
    configure(0, 0);
    measure(200, n);
    check(n == 0, "R5 idle no request", n, 0);

    // R5/R6 start
    wr(2'd0, 16'hCCCC);
    measure(100, n);
    check(n == 4, "R5 R6 start window", n, 4);

    // R6 R7 R9 sweep
    for (int pr = 0; pr < 8; pr++) begin
      for (int ri = 0; ri < 2; ri++) begin
        int rl = ri * 2;
        configure(pr, rl);
        wr(2'd0, 16'hAAAA);
        exp = window(pr, rl);
        measure(exp + 10, n);
        check(n == exp, (pr == 7) ? "R7 code 7 window" : "R6 window", n, exp);
        @(negedge clk_i);
        check(rst_req_o == 1'b0, "R9 pulse width", int'(rst_req_o), 0);
        measure(exp + 10, n);
        check(n == exp, "R9 auto reload window", n, exp);
      end
    end

    // R6 full reload range
    configure(0, 12'hFFF);
    wr(2'd0, 16'hAAAA);
    exp = window(0, 12'hFFF);
    measure(exp + 10, n);
    check(n == exp, "R6 max reload window", n, exp);

    // R8 refresh mid-window
    configure(0, 9);
    wr(2'd0, 16'hAAAA);
    repeat (30) begin
      @(negedge clk_i); tick_i = 1'b1;
    end
    @(negedge clk_i); tick_i = 1'b0;
    check(rst_req_o == 1'b0, "R8 no early request", int'(rst_req_o), 0);
    wr(2'd0, 16'hAAAA);
    measure(100, n);
    check(n == 40, "R8 refresh restarts", n, 40);

    // R10 stop attempts
    wr(2'd0, 16'hAAAA);
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'hFFFF);
    wr(2'd0, 16'hCCCC);
    wr(2'd3, 16'hFFFF);
    measure(100, n);
    check(n == 40, "R10 still running", n, 40);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule